// File: doc/BRIEF.md
# NOR Cell Array Erase and Program Engine

This block holds a small synchronous byte array that behaves like NOR flash cells, and it runs the program and erase requests that a command sequencer hands it. A program request merges one data byte into the array. An erase request fills a region with 0xFF, one byte per clock, starting at the supplied address. Four region sizes are available: 4 KiB, 32 KiB, one sector, or the whole array. The sequencer also supplies the current write-enable state with each request. The engine returns a busy level, a one-cycle done pulse, and three error or diagnostic flags that are valid only with that pulse.

Parameters set the sector size, the sector count, whether 4 KiB and 32 KiB erases are supported, and whether programming may turn bits from 0 back to 1. The two kinds of error behave differently. An erase without write enable is refused. An erase of an unsupported size is flagged but still performed. A byte program is never blocked, even when write enable is clear. A synchronous read port lets the sequencer fetch array contents.

Top module: `flash_erase_engine`

## Requirements
- R1: After reset, `busy`, `done` and all three flags are 0, every byte of the array (SECTOR_BYTES × SECTOR_COUNT bytes) reads 0xFF, and `rd_data` is 0 until the first read.
- R2: A program request (`req_op` = 0x02) accepted at clock edge k stores old AND `req_data` at `req_addr`. `busy` is high for one cycle. `done` pulses for one cycle after edge k+1.
- R3: With OVERWRITE = 1, a program stores `req_data` unchanged, so bits may go from 0 to 1.
- R4: An erase request made while `wr_en` is 0 changes no byte and never raises `busy`. `done` and `err_prot` pulse together in the next cycle.
- R5: A 4 KiB erase (0x20) when CAN_4K is 0, or a 32 KiB erase (0x52) when CAN_32K is 0, raises `err_size` with `done`. The erase is still performed when `wr_en` is 1.
- R6: An erase writes 0xFF from the start address for 4096 bytes (0x20), 32768 bytes (0x52) or SECTOR_BYTES bytes (0xD8), clipped at the end of the array. It writes one byte per cycle with `busy` high for exactly that many cycles, then gives a one-cycle `done`.
- R7: A bulk erase (0xC7) starts at address 0 whatever `req_addr` holds, and it fills the whole array.
- R8: `err_rise` pulses with the `done` of a program when (old XOR new) AND new is nonzero.
- R9: A program with `wr_en` at 0 still updates the array and raises `err_prot` with `done`.
- R10: A request presented while `busy` is high is ignored. So is a request with any other `req_op` value.
- R11: `rd_data` holds the byte at `rd_addr` as it was at the previous clock edge. A write on that same edge is not yet visible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_op | input | 8 | Request code: 0x02, 0x20, 0x52, 0xD8, 0xC7 |
| req_addr | input | AW | Byte address of program or erase start |
| req_data | input | 8 | Program data byte |
| wr_en | input | 1 | Write-enable state from the sequencer |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err_prot | output | 1 | Write-enable violation, valid with done |
| err_size | output | 1 | Unsupported erase size, valid with done |
| err_rise | output | 1 | Program tried to set a cleared bit, valid with done |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Read data, one-cycle latency |

## Verification
A wrong erase pointer or remaining count shows up first at `busy` and `done`. The completion pulse lands early or late on the first erase whose length disagrees. A misplaced fill shows up at `rd_data` within one pass of the sweeping read address. A faulty merge or flag path shows up in the cycle after the program completes, either as a wrong `err_rise` or `err_prot` with `done`, or as a wrong byte at the next read of that address. Because the reference model is compared on every clock, a fault is reported in the first cycle where it becomes visible.

// File: rtl/flash_eng_pkg.sv
// Shared request codes and engine state encoding for the erase/program engine.
package flash_eng_pkg;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_ER4K  = 8'h20;
    localparam logic [7:0] OP_ER32K = 8'h52;
    localparam logic [7:0] OP_ERSEC = 8'hD8;
    localparam logic [7:0] OP_ERALL = 8'hC7;

    localparam int unsigned SMALL_SPAN = 4096;
    localparam int unsigned LARGE_SPAN = 32768;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PGM   = 2'd1,
        ST_ERASE = 2'd2
    } eng_state_e;
endpackage

// File: rtl/flash_cell_array.sv
// Byte array that stands in for NOR cells.
// One write port and two synchronous read ports (internal and external).
// Assumes DEPTH == 2**AW. Reset fills every byte with 0xFF.
module flash_cell_array #(
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] ra_addr,
    output logic [7:0]    ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [7:0]    rb_data
);
    logic [7:0] cells [DEPTH];

    // Cell storage: erased state on reset, otherwise one byte written per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= 8'hFF;
            end
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Read registers: both ports return the content from before this edge's write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ra_data <= 8'h00;
            rb_data <= 8'h00;
        end else begin
            ra_data <= cells[ra_addr];
            rb_data <= cells[rb_addr];
        end
    end
endmodule

// File: rtl/flash_region_calc.sv
// Decodes a request code into erase start, byte count and size-support flag.
// Assumes the start address is below TOTAL, so the count is never zero.
module flash_region_calc
    import flash_eng_pkg::*;
#(
    parameter int TOTAL        = 2048,
    parameter int SECTOR_BYTES = 512,
    parameter bit CAN_4K       = 1'b1,
    parameter bit CAN_32K      = 1'b0,
    parameter int AW           = 11,
    parameter int CW           = 12
) (
    input  logic [7:0]    op,
    input  logic [AW-1:0] addr,
    output logic          is_erase,
    output logic          unsupported,
    output logic [AW-1:0] start,
    output logic [CW-1:0] count
);
    logic [31:0] span;
    logic [31:0] room;

    // Region decode: pick the span, the start point and clip at the array end.
    always_comb begin
        is_erase    = 1'b1;
        unsupported = 1'b0;
        span        = 32'(SECTOR_BYTES);
        case (op)
            OP_ER4K: begin
                span        = 32'(SMALL_SPAN);
                unsupported = !CAN_4K;
            end
            OP_ER32K: begin
                span        = 32'(LARGE_SPAN);
                unsupported = !CAN_32K;
            end
            OP_ERSEC: span = 32'(SECTOR_BYTES);
            OP_ERALL: span = 32'(TOTAL);
            default:  is_erase = 1'b0;
        endcase
        start = (op == OP_ERALL) ? '0 : addr;
        room  = 32'(TOTAL) - 32'(start);
        count = CW'((span < room) ? span : room);
    end
endmodule

// File: rtl/flash_bit_merge.sv
// Merges a program byte into an old cell value and detects 0-to-1 attempts.
// OVERWRITE selects direct store instead of the AND merge of NOR cells.
module flash_bit_merge #(
    parameter bit OVERWRITE = 1'b0
) (
    input  logic [7:0] old_val,
    input  logic [7:0] new_val,
    output logic [7:0] merged,
    output logic       rise
);
    // Diagnostic: some bit that is 0 now would be asked to become 1.
    assign rise = |((old_val ^ new_val) & new_val);

    generate
        if (OVERWRITE) begin : g_direct
            // Direct store: the new byte replaces the old one.
            assign merged = new_val;
        end else begin : g_nor
            // NOR semantics: programming can only clear bits.
            assign merged = old_val & new_val;
        end
    endgenerate
endmodule

// File: rtl/flash_erase_engine.sv
// Erase/program engine over a NOR-like byte array.
// Accepts one request when idle. A program takes a read cycle and a write cycle.
// An erase fills 0xFF one byte per clock. Flags are valid only with done.
// Assumes SECTOR_BYTES*SECTOR_COUNT is a power of two.
module flash_erase_engine
    import flash_eng_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int SECTOR_COUNT = 4,
    parameter bit CAN_4K       = 1'b1,
    parameter bit CAN_32K      = 1'b0,
    parameter bit OVERWRITE    = 1'b0,
    localparam int TOTAL       = SECTOR_BYTES * SECTOR_COUNT,
    localparam int AW          = $clog2(TOTAL),
    localparam int CW          = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [7:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    input  logic          wr_en,
    output logic          busy,
    output logic          done,
    output logic          err_prot,
    output logic          err_size,
    output logic          err_rise,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    eng_state_e    st;
    logic [AW-1:0] ptr;
    logic [CW-1:0] left;
    logic [AW-1:0] pgm_addr;
    logic [7:0]    pgm_data;
    logic          pgm_we;
    logic          size_bad;

    logic          is_erase;
    logic          unsup;
    logic [AW-1:0] er_start;
    logic [CW-1:0] er_count;
    logic [7:0]    old_val;
    logic [7:0]    merged;
    logic          rise;
    logic          arr_we;
    logic [AW-1:0] arr_waddr;
    logic [7:0]    arr_wdata;

    flash_region_calc #(
        .TOTAL(TOTAL), .SECTOR_BYTES(SECTOR_BYTES), .CAN_4K(CAN_4K),
        .CAN_32K(CAN_32K), .AW(AW), .CW(CW)
    ) u_region (
        .op(req_op), .addr(req_addr), .is_erase(is_erase),
        .unsupported(unsup), .start(er_start), .count(er_count)
    );

    flash_bit_merge #(.OVERWRITE(OVERWRITE)) u_merge (
        .old_val(old_val), .new_val(pgm_data), .merged(merged), .rise(rise)
    );

    flash_cell_array #(.DEPTH(TOTAL), .AW(AW)) u_cells (
        .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(arr_waddr),
        .wdata(arr_wdata), .ra_addr(req_addr), .ra_data(old_val),
        .rb_addr(rd_addr), .rb_data(rd_data)
    );

    // Write port steering: merged byte in the program cycle, 0xFF while erasing.
    always_comb begin
        arr_we    = (st == ST_PGM) || (st == ST_ERASE);
        arr_waddr = (st == ST_PGM) ? pgm_addr : ptr;
        arr_wdata = (st == ST_PGM) ? merged : 8'hFF;
    end

    assign busy = (st != ST_IDLE);

    // Sequencing: accept requests, run program and erase, pulse done and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            ptr      <= '0;
            left     <= '0;
            pgm_addr <= '0;
            pgm_data <= 8'h00;
            pgm_we   <= 1'b0;
            size_bad <= 1'b0;
            done     <= 1'b0;
            err_prot <= 1'b0;
            err_size <= 1'b0;
            err_rise <= 1'b0;
        end else begin
            done     <= 1'b0;
            err_prot <= 1'b0;
            err_size <= 1'b0;
            err_rise <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_valid && req_op == OP_PROG) begin
                        st       <= ST_PGM;
                        pgm_addr <= req_addr;
                        pgm_data <= req_data;
                        pgm_we   <= wr_en;
                    end else if (req_valid && is_erase) begin
                        if (!wr_en) begin
                            done     <= 1'b1;
                            err_prot <= 1'b1;
                            err_size <= unsup;
                        end else begin
                            st       <= ST_ERASE;
                            ptr      <= er_start;
                            left     <= er_count - 1'b1;
                            size_bad <= unsup;
                        end
                    end
                end
                ST_PGM: begin
                    st       <= ST_IDLE;
                    done     <= 1'b1;
                    err_prot <= !pgm_we;
                    err_rise <= rise;
                end
                ST_ERASE: begin
                    if (left == '0) begin
                        st       <= ST_IDLE;
                        done     <= 1'b1;
                        err_size <= size_bad;
                    end else begin
                        ptr  <= ptr + 1'b1;
                        left <= left - 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4
    flags_need_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_prot || err_size || err_rise) |-> done);

    // R2
    pgm_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PGM) |=> (done && st == ST_IDLE));

    // R6
    erase_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERASE && left != '0) |=> (left == $past(left) - 1'b1 && busy));

    // R6
    erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERASE) |-> (arr_we && arr_wdata == 8'hFF));
endmodule

// File: tb/flash_erase_engine_test.sv
module flash_erase_engine_test;
    localparam int SEC   = 512;
    localparam int CNT   = 4;
    localparam int TOTAL = SEC * CNT;
    localparam int AW    = $clog2(TOTAL);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          req_valid = 1'b0;
    logic [7:0]    req_op = 8'h00;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = 8'h00;
    logic          wr_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          busy, done, err_prot, err_size, err_rise;
    logic [7:0]    rd_data;

    flash_erase_engine #(.SECTOR_BYTES(SEC), .SECTOR_COUNT(CNT), .CAN_4K(1'b1),
                         .CAN_32K(1'b0), .OVERWRITE(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .wr_en(wr_en), .busy(busy),
        .done(done), .err_prot(err_prot), .err_size(err_size), .err_rise(err_rise),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Second instance with direct overwrite for R3.
    logic       ow_valid = 1'b0;
    logic [6:0] ow_addr = '0;
    logic [7:0] ow_data = 8'h00;
    logic [6:0] ow_rd_addr = '0;
    logic       ow_busy, ow_done, ow_prot, ow_size, ow_rise;
    logic [7:0] ow_rd_data;

    flash_erase_engine #(.SECTOR_BYTES(64), .SECTOR_COUNT(2), .CAN_4K(1'b1),
                         .CAN_32K(1'b1), .OVERWRITE(1'b1)) uut_ow (
        .clk(clk), .rst_n(rst_n), .req_valid(ow_valid), .req_op(8'h02),
        .req_addr(ow_addr), .req_data(ow_data), .wr_en(1'b1), .busy(ow_busy),
        .done(ow_done), .err_prot(ow_prot), .err_size(ow_size), .err_rise(ow_rise),
        .rd_addr(ow_rd_addr), .rd_data(ow_rd_data)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // Behavioural reference model.
    logic [7:0] m_mem [TOTAL];
    int   m_st = 0, m_ptr = 0, m_left = 0, m_pa = 0;
    logic [7:0] m_pd;
    bit   m_pwe, m_psize;
    bit   e_busy, e_done, e_prot, e_size, e_rise;
    logic [7:0] e_rd;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < TOTAL; i++) m_mem[i] = 8'hFF;
            m_st = 0; e_busy = 0; e_done = 0; e_prot = 0; e_size = 0; e_rise = 0;
            e_rd = 8'h00;
        end else begin
            e_rd = m_mem[rd_addr];
            e_done = 0; e_prot = 0; e_size = 0; e_rise = 0;
            if (m_st == 0) begin
                if (req_valid && req_op == 8'h02) begin
                    m_st = 1; m_pa = req_addr; m_pd = req_data; m_pwe = wr_en;
                end else if (req_valid && (req_op == 8'h20 || req_op == 8'h52 ||
                                           req_op == 8'hD8 || req_op == 8'hC7)) begin
                    int span, start;
                    bit bad;
                    bad = (req_op == 8'h52);
                    span = (req_op == 8'h20) ? 4096 : (req_op == 8'h52) ? 32768 :
                           (req_op == 8'hD8) ? SEC : TOTAL;
                    start = (req_op == 8'hC7) ? 0 : int'(req_addr);
                    if (!wr_en) begin
                        e_done = 1; e_prot = 1; e_size = bad;
                    end else begin
                        m_st = 2; m_ptr = start; m_psize = bad;
                        m_left = (span < TOTAL - start) ? span : TOTAL - start;
                    end
                end
            end else if (m_st == 1) begin
                logic [7:0] old;
                old = m_mem[m_pa];
                e_rise = ((old ^ m_pd) & m_pd) != 0;
                m_mem[m_pa] = old & m_pd;
                e_prot = !m_pwe; e_done = 1; m_st = 0;
            end else begin
                m_mem[m_ptr] = 8'hFF;
                m_ptr++; m_left--;
                if (m_left == 0) begin
                    e_done = 1; e_size = m_psize; m_st = 0;
                end
            end
            e_busy = (m_st != 0);
        end
    end

    task automatic cmp(string sig, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, sig, act, exp);
        end
    endtask

    // Compare every clock away from the active edge; sweep the read address.
    always @(negedge clk) begin
        if (cyc >= 2) begin
            cmp("busy", {7'd0, busy}, {7'd0, e_busy});
            cmp("done", {7'd0, done}, {7'd0, e_done});
            cmp("err_prot", {7'd0, err_prot}, {7'd0, e_prot});
            cmp("err_size", {7'd0, err_size}, {7'd0, e_size});
            cmp("err_rise", {7'd0, err_rise}, {7'd0, e_rise});
            cmp("rd_data R11", rd_data, e_rd);
        end
        rd_addr <= rd_addr + 1'b1;
    end

    task automatic issue(logic [7:0] op, int addr, logic [7:0] d, logic we);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = AW'(addr); req_data = d; wr_en = we;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic ow_prog(int a, logic [7:0] d, logic exp_rise, string req);
        @(negedge clk);
        ow_valid = 1'b1; ow_addr = 7'(a); ow_data = d;
        @(negedge clk);
        ow_valid = 1'b0;
        @(negedge clk);
        cur_req = req;
        cmp("ow_done", {7'd0, ow_done}, 8'd1);
        cmp("ow_rise", {7'd0, ow_rise}, {7'd0, exp_rise});
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1"; repeat (TOTAL + 4) @(negedge clk);
        cur_req = "R2"; issue(8'h02, 10, 8'h5A, 1'b1);
        cur_req = "R8"; issue(8'h02, 10, 8'hFF, 1'b1);
        cur_req = "R8"; issue(8'h02, 11, 8'h3C, 1'b1);
        cur_req = "R9"; issue(8'h02, 20, 8'h0F, 1'b0);
        cur_req = "R4"; issue(8'hD8, 0, 8'h00, 1'b0);
        cur_req = "R4"; issue(8'h20, 0, 8'h00, 1'b0);
        cur_req = "R6"; issue(8'hD8, 8, 8'h00, 1'b1);
        cur_req = "R2"; issue(8'h02, 1500, 8'h00, 1'b1);
        cur_req = "R6"; issue(8'h20, 1000, 8'h00, 1'b1);
        cur_req = "R5"; issue(8'h02, 1600, 8'h12, 1'b1);
        cur_req = "R5"; issue(8'h52, 1500, 8'h00, 1'b1);
        cur_req = "R5"; issue(8'h52, 4, 8'h00, 1'b0);
        cur_req = "R10";
        issue(8'h9F, 30, 8'h00, 1'b1);
        issue(8'h02, 30, 8'h00, 1'b1);
        @(negedge clk);
        req_valid = 1'b1; req_op = 8'hD8; req_addr = AW'(512); wr_en = 1'b1;
        @(negedge clk);
        req_op = 8'h02; req_addr = AW'(31); req_data = 8'h00;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        cur_req = "R7";
        issue(8'h02, 40, 8'h00, 1'b1);
        issue(8'hC7, 777, 8'h00, 1'b1);
        cur_req = "R11"; repeat (TOTAL + 4) @(negedge clk);

        cur_req = "R3";
        ow_prog(3, 8'h0F, 1'b0, "R3");
        ow_prog(3, 8'hF0, 1'b1, "R3");
        ow_rd_addr = 7'd3;
        repeat (2) @(negedge clk);
        cmp("ow_rd_data", ow_rd_data, 8'hF0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule